// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block holds a handful of recent page translations and turns a virtual byte address into a narrower physical byte address. The upper bits of the incoming address (the virtual page number) are compared at once against the page number held in every entry. When a valid entry matches, the result carries that entry's physical frame number followed by the untouched in-page offset, together with the control bits stored in the entry. When no valid entry matches, the result flags a miss. Lookups use a valid/ready request channel and produce a registered response one cycle after acceptance on a valid/ready response channel.

Refills come from outside. A fill writes a page number, a frame number and control bits. If the page is already held, its entry is rewritten in place. Otherwise the entry chosen by a round-robin pointer is overwritten and the pointer moves on. A flush pulse invalidates every entry in a single cycle. Fill and flush are plain control inputs that are always accepted.

Back-pressure rules: `req_ready` is high whenever the response register is empty or is being drained in the same cycle (`!rsp_valid || rsp_ready`). While `rsp_valid` is high and `rsp_ready` is low, the response holds all its fields unchanged and no new request is taken.

Top module: `tlb_fa`

## Requirements
- R1: After reset no entry is valid, `rsp_valid` is 0, `req_ready` is 1, and any lookup reports a miss.
- R2: The response to a request accepted on clock edge N appears with `rsp_valid` high after edge N. On a hit, `rsp_hit` is 1, `rsp_paddr` is the stored frame number in its upper PA_W-OFS_W bits, and `rsp_ctrl` is the stored control value.
- R3: When no valid entry holds the request's page number, `rsp_hit` is 0 and both `rsp_paddr` and `rsp_ctrl` are 0.
- R4: On a hit, bits OFS_W-1:0 of `rsp_paddr` equal bits OFS_W-1:0 of the request address.
- R5: A fill whose page number is not held writes the entry at the round-robin pointer and advances the pointer by one, wrapping after ENTRIES-1. With ENTRIES distinct pages held, one more distinct fill evicts the oldest fill.
- R6: A fill whose page number is already held rewrites that entry's frame and control bits and does not advance the pointer. No second copy of the page is created.
- R7: A flush invalidates every entry in one cycle and returns the pointer to entry 0. Lookups accepted after the flush edge miss.
- R8: When fill and flush are asserted in the same cycle, the flush wins and the fill is dropped.
- R9: A lookup accepted on the same edge as a fill sees the contents from before that fill. A lookup accepted on a later edge sees the fill.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, `req_ready` is 0 and `rsp_hit`, `rsp_paddr` and `rsp_ctrl` are held.
- R11: At most one valid entry ever matches a given page number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be taken |
| req_vaddr | input | VA_W | Virtual byte address to translate |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_hit | output | 1 | 1 on hit, 0 on miss |
| rsp_paddr | output | PA_W | Physical byte address (0 on miss) |
| rsp_ctrl | output | CTRL_W | Control bits of the hit entry (0 on miss) |
| fill_valid | input | 1 | Write a translation this cycle |
| fill_vpn | input | VA_W-OFS_W | Page number to install |
| fill_pfn | input | PA_W-OFS_W | Frame number to install |
| fill_ctrl | input | CTRL_W | Control bits to install |
| flush | input | 1 | Invalidate all entries |

## Verification
The bench builds the block with a 32-bit virtual address, a 28-bit physical address, a 12-bit offset, four entries and 3 control bits. Four entries keep the round-robin wrap and eviction within a few fills. The random page numbers are drawn from a pool of six, only slightly larger than the buffer, so rewrites of held pages, evictions and misses all occur often. The narrow control field still shows that control bits are carried apart from the frame number.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    FILL_IDLE    = 2'd0,
    FILL_NEW     = 2'd1,
    FILL_REWRITE = 2'd2
  } fill_kind_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = tlb_pkg::idx_width(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  output logic [IDX_W-1:0] ptr
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      ptr <= '0;
    end else if (advance) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end

  assert_ptr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> ptr == '0);

  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !advance) |=> $stable(ptr));

  assert_ptr_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST);

endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 16,
  parameter int CTRL_W  = 4,
  localparam int IDX_W  = tlb_pkg::idx_width(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic [CTRL_W-1:0] wr_ctrl,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [CTRL_W-1:0] lk_ctrl,
  input  logic [VPN_W-1:0]  probe_vpn,
  output logic              probe_hit,
  output logic [IDX_W-1:0]  probe_idx
);

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [CTRL_W-1:0]  ctrl_q [ENTRIES];
  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] probe_match;

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
        vpn_q[i]   <= '0;
        pfn_q[i]   <= '0;
        ctrl_q[i]  <= '0;
      end else if (flush) begin
        valid_q[i] <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        valid_q[i] <= 1'b1;
        vpn_q[i]   <= wr_vpn;
        pfn_q[i]   <= wr_pfn;
        ctrl_q[i]  <= wr_ctrl;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g]    = valid_q[g] && (vpn_q[g] == lk_vpn);
    assign probe_match[g] = valid_q[g] && (vpn_q[g] == probe_vpn);
  end

  always_comb begin
    lk_pfn    = '0;
    lk_ctrl   = '0;
    probe_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        lk_pfn  = lk_pfn | pfn_q[i];
        lk_ctrl = lk_ctrl | ctrl_q[i];
      end
      if (probe_match[i]) probe_idx = probe_idx | IDX_W'(i);
    end
  end

  assign lk_hit    = |lk_match;
  assign probe_hit = |probe_match;

  assert_single_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  assert_single_probe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(probe_match));

  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> valid_q == '0);

  assert_write_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |=> $countones(valid_q) >= 1);

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 28,
  parameter int OFS_W   = 12,
  parameter int ENTRIES = 8,
  parameter int CTRL_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [VA_W-1:0]         req_vaddr,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic                    rsp_hit,
  output logic [PA_W-1:0]         rsp_paddr,
  output logic [CTRL_W-1:0]       rsp_ctrl,
  input  logic                    fill_valid,
  input  logic [VA_W-OFS_W-1:0]   fill_vpn,
  input  logic [PA_W-OFS_W-1:0]   fill_pfn,
  input  logic [CTRL_W-1:0]       fill_ctrl,
  input  logic                    flush
);
  import tlb_pkg::*;

  localparam int VPN_W = VA_W - OFS_W;
  localparam int PFN_W = PA_W - OFS_W;
  localparam int IDX_W = idx_width(ENTRIES);

  logic              lk_hit;
  logic [PFN_W-1:0]  lk_pfn;
  logic [CTRL_W-1:0] lk_ctrl;
  logic              probe_hit;
  logic [IDX_W-1:0]  probe_idx;
  logic [IDX_W-1:0]  rr_ptr;
  logic [IDX_W-1:0]  wr_idx;
  logic              wr_en;
  logic              req_fire;
  fill_kind_e        fill_kind;

  always_comb begin
    if (!fill_valid || flush) fill_kind = FILL_IDLE;
    else if (probe_hit)       fill_kind = FILL_REWRITE;
    else                      fill_kind = FILL_NEW;
  end

  assign wr_en  = fill_kind != FILL_IDLE;
  assign wr_idx = (fill_kind == FILL_REWRITE) ? probe_idx : rr_ptr;

  tlb_entry_array #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .CTRL_W(CTRL_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(fill_vpn),
    .wr_pfn(fill_pfn), .wr_ctrl(fill_ctrl),
    .lk_vpn(req_vaddr[VA_W-1:OFS_W]), .lk_hit(lk_hit),
    .lk_pfn(lk_pfn), .lk_ctrl(lk_ctrl),
    .probe_vpn(fill_vpn), .probe_hit(probe_hit), .probe_idx(probe_idx)
  );

  tlb_rr_ptr #(.ENTRIES(ENTRIES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clear(flush),
    .advance(fill_kind == FILL_NEW), .ptr(rr_ptr)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_paddr <= '0;
      rsp_ctrl  <= '0;
    end else if (req_fire) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= lk_hit;
      rsp_paddr <= lk_hit ? {lk_pfn, req_vaddr[OFS_W-1:0]} : '0;
      rsp_ctrl  <= lk_hit ? lk_ctrl : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_rsp_after_fire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> rsp_valid);

  assert_offset_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> (!rsp_hit || rsp_paddr[OFS_W-1:0] == $past(req_vaddr[OFS_W-1:0])));

  assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0 && rsp_ctrl == '0));

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) &&
                                   $stable(rsp_paddr) && $stable(rsp_ctrl)));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_flush_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !req_fire) |=> !lk_hit);

endmodule

// File: tb/tlb_fa_tb.sv
`timescale 1ns/1ps
module tlb_fa_tb;
  localparam int VA_W = 32, PA_W = 28, OFS_W = 12, N = 4, CW = 3;
  localparam int VPN_W = VA_W - OFS_W, PFN_W = PA_W - OFS_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b1, fill_valid = 1'b0, flush = 1'b0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [PFN_W-1:0] fill_pfn = '0;
  logic [CW-1:0] fill_ctrl = '0;
  logic req_ready, rsp_valid, rsp_hit;
  logic [PA_W-1:0] rsp_paddr;
  logic [CW-1:0] rsp_ctrl;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic             m_valid [N];
  logic [VPN_W-1:0] m_vpn   [N];
  logic [PFN_W-1:0] m_pfn   [N];
  logic [CW-1:0]    m_ctrl  [N];
  int               m_ptr;

  always #5 clk = ~clk;

  tlb_fa #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .ENTRIES(N), .CTRL_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_ctrl(rsp_ctrl),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_ctrl(fill_ctrl), .flush(flush));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 1'b0; m_vpn[i] = '0; m_pfn[i] = '0; m_ctrl[i] = '0;
    end
    m_ptr = 0;
  endfunction

  function automatic void model_lookup(input logic [VA_W-1:0] va, output logic h,
                                       output logic [PA_W-1:0] pa, output logic [CW-1:0] c);
    h = 1'b0; pa = '0; c = '0;
    for (int i = 0; i < N; i++)
      if (m_valid[i] && m_vpn[i] == va[VA_W-1:OFS_W]) begin
        h = 1'b1; pa = {m_pfn[i], va[OFS_W-1:0]}; c = m_ctrl[i];
      end
  endfunction

  function automatic void model_apply(input bit fv, input bit fl, input logic [VPN_W-1:0] v,
                                      input logic [PFN_W-1:0] p, input logic [CW-1:0] c);
    int slot;
    if (fl) begin
      for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
      m_ptr = 0;
      return;
    end
    if (!fv) return;
    slot = -1;
    for (int i = 0; i < N; i++) if (m_valid[i] && m_vpn[i] == v) slot = i;
    if (slot < 0) begin
      slot = m_ptr;
      m_ptr = (m_ptr + 1) % N;
    end
    m_valid[slot] = 1'b1; m_vpn[slot] = v; m_pfn[slot] = p; m_ctrl[slot] = c;
  endfunction

  // Single cycle: optional lookup, optional fill, optional flush; checks the response.
  task automatic step(input string tag, input bit lk, input logic [VA_W-1:0] va,
                      input bit fv, input logic [VPN_W-1:0] v, input logic [PFN_W-1:0] p,
                      input logic [CW-1:0] c, input bit fl);
    logic eh; logic [PA_W-1:0] ep; logic [CW-1:0] ec;
    model_lookup(va, eh, ep, ec);
    @(negedge clk);
    req_valid = lk; req_vaddr = va; rsp_ready = 1'b1;
    fill_valid = fv; fill_vpn = v; fill_pfn = p; fill_ctrl = c; flush = fl;
    @(negedge clk);
    req_valid = 1'b0; fill_valid = 1'b0; flush = 1'b0;
    model_apply(fv, fl, v, p, c);
    chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'(lk));
    if (lk) begin
      chk({tag, " hit"}, 64'(rsp_hit), 64'(eh));
      chk({tag, " paddr"}, 64'(rsp_paddr), 64'(ep));
      chk({tag, " ctrl"}, 64'(rsp_ctrl), 64'(ec));
    end
  endtask

  task automatic lookup(input string tag, input logic [VA_W-1:0] va);
    step(tag, 1'b1, va, 1'b0, '0, '0, '0, 1'b0);
  endtask

  task automatic fill(input logic [VPN_W-1:0] v, input logic [PFN_W-1:0] p, input logic [CW-1:0] c);
    step("fill", 1'b0, '0, 1'b1, v, p, c, 1'b0);
  endtask

  function automatic logic [VA_W-1:0] va_of(input logic [VPN_W-1:0] v, input logic [OFS_W-1:0] o);
    return {v, o};
  endfunction

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic eh; logic [PA_W-1:0] ep; logic [CW-1:0] ec;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 req_ready", 64'(req_ready), 64'd1);
    lookup("R1 lookup after reset", va_of(20'h00000, 12'h000));

    // R2 R4: hit with frame substitution, offset untouched
    fill(20'h12345, 16'hBEEF, 3'd5);
    lookup("R2 R4 hit", va_of(20'h12345, 12'hA5C));
    lookup("R4 offset max", va_of(20'h12345, 12'hFFF));
    // R3: miss on neighbouring page
    lookup("R3 miss", va_of(20'h12346, 12'h123));

    // R6: rewrite of a held page, pointer does not move
    fill(20'h12345, 16'h0042, 3'd2);
    lookup("R6 rewrite", va_of(20'h12345, 12'h010));

    // R5: wrap and eviction of the oldest new fill
    step("R7 flush", 1'b0, '0, 1'b0, '0, '0, '0, 1'b1);
    for (int k = 1; k <= N + 1; k++) fill(VPN_W'(k), PFN_W'(16'h100 + k), CW'(k));
    lookup("R5 evicted oldest", va_of(20'd1, 12'h004));
    lookup("R5 second kept", va_of(20'd2, 12'h008));
    lookup("R5 newest in slot0", va_of(20'd5, 12'h00C));
    // R6: rewrite then new fill lands where the pointer was (slot1 evicts page 2)
    fill(20'd3, 16'h0333, 3'd7);
    fill(20'd9, 16'h0999, 3'd1);
    lookup("R6 pointer held, page2 evicted", va_of(20'd2, 12'h000));
    lookup("R6 page3 rewritten kept", va_of(20'd3, 12'h000));

    // R7: flush clears everything and resets the pointer
    step("R7 flush", 1'b0, '0, 1'b0, '0, '0, '0, 1'b1);
    lookup("R7 miss after flush", va_of(20'd9, 12'h000));
    fill(20'h00077, 16'h7777, 3'd3);
    fill(20'h00078, 16'h7878, 3'd4);
    lookup("R7 refill after flush", va_of(20'h00077, 12'h001));

    // R8: flush beats a same-cycle fill
    step("R8 flush+fill", 1'b0, '0, 1'b1, 20'h00055, 16'h5555, 3'd6, 1'b1);
    lookup("R8 fill dropped", va_of(20'h00055, 12'h000));

    // R9: same-cycle lookup sees old contents, next sees the fill
    step("R9 same cycle", 1'b1, va_of(20'h00066, 12'h0AB), 1'b1, 20'h00066, 16'h6666, 3'd2, 1'b0);
    lookup("R9 next cycle", va_of(20'h00066, 12'h0AB));

    // R10: back-pressure holds the response
    model_lookup(va_of(20'h00066, 12'h111), eh, ep, ec);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va_of(20'h00066, 12'h111); rsp_ready = 1'b0;
    @(negedge clk);
    chk("R10 valid under stall", 64'(rsp_valid), 64'd1);
    chk("R10 req_ready low", 64'(req_ready), 64'd0);
    req_vaddr = va_of(20'h00012, 12'h222);
    @(negedge clk);
    chk("R10 paddr held", 64'(rsp_paddr), 64'(ep));
    chk("R10 hit held", 64'(rsp_hit), 64'(eh));
    chk("R10 ctrl held", 64'(rsp_ctrl), 64'(ec));
    model_lookup(va_of(20'h00012, 12'h222), eh, ep, ec);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 next accepted on drain", 64'(rsp_valid), 64'd1);
    chk("R10 next hit", 64'(rsp_hit), 64'(eh));
    chk("R10 next paddr", 64'(rsp_paddr), 64'(ep));
    @(negedge clk);
    chk("R10 drained", 64'(rsp_valid), 64'd0);

    // Random mix (R2 R3 R5 R6 R9 R11)
    for (int it = 0; it < 600; it++) begin
      int op;
      logic [VPN_W-1:0] v;
      v = VPN_W'(20'h00A00 + ($urandom % 6));
      op = $urandom % 20;
      step("R11 random", op < 12,
           va_of(VPN_W'(20'h00A00 + ($urandom % 6)), OFS_W'($urandom)),
           op >= 6, v, PFN_W'($urandom), CW'($urandom), op == 19);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule